// File: doc/BRIEF.md
# Runtime Profiling and Event Trace Unit

This block watches instrumented signals inside a running design and keeps measurement data that host software can read without stopping the application. It has a free-running global cycle counter. It also has a bank of profile counters. Each profile counter adds up the clock cycles in which a monitored state machine sits in the state assigned to it.

A user event marks a moment the host wants to know about, such as a core finishing its work. On each event the block stores a timestamped record in a circular trace FIFO. When the FIFO is full, the record is thrown away and a dropped-record count goes up, so the application never stalls. Counter wrap is latched in sticky overflow flags. From the drop count and the overflow flags the host can judge how far to trust the data.

The host reaches the block through a small word-addressed register port. Reads have no latency and can happen at any time. Reading the trace window pops one 32-bit word of the head record per strobe. A write to the control register issues a clear, sets the stop state, or releases it.

Top module: `prof_trace_unit`

## Requirements
- R1: The global cycle counter at address 0x01 goes up by one in every clock cycle while the unit runs. When it wraps from all ones to zero, status bit 2 is set.
- R2: Profile counter i, at address 0x10+i, goes up by one in every running cycle in which `prof_hit_i[i]` is high. Register reads other than the trace window leave all state unchanged.
- R3: A profile counter that would pass its maximum value stays at that maximum. At the same moment its overflow bit, status bit 16+i, is set and stays set until a clear.
- R4: An event accepted in a cycle stores a record of three words. Word 0 holds the cycle counter value of that cycle. Word 1 holds `evt_data_i[31:0]` and word 2 holds `evt_data_i[63:32]`. The records come out in arrival order.
- R5: Each read strobe at address 0x03 returns the next word of the head record, in the order word 0, word 1, word 2. The read that returns word 2 removes the record. Occupancy is shown in status bits 15:8 and the empty flag in status bit 0. A read of an empty FIFO returns zero and changes nothing.
- R6: When an event arrives while the FIFO holds TRACE_DEPTH records, the event is discarded, the stored records stay as they are, and the drop count at address 0x02 goes up by one. The full flag is status bit 3.
- R7: Writing 1 to control bit 1 (address 0x00) stops the unit. While stopped, all counters hold their values, events are ignored and status bit 1 reads 1. Writing 0 to control bit 1 resumes counting.
- R8: Writing 1 to control bit 0 at address 0x00 zeroes every counter, the drop count and all overflow flags, and empties the trace FIFO.
- R9: An event that arrives in the same cycle as a clear is not recorded.
- R10: After reset all counters read zero, the unit runs, and status reads 0x00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prof_hit_i | input | N_CNT | Bit i is high while the monitored machine is in the state of counter i |
| evt_valid_i | input | 1 | A trace event occurs in this cycle |
| evt_data_i | input | 64 | Payload of the event |
| reg_addr_i | input | 6 | Register word address |
| reg_rd_i | input | 1 | Read strobe; pops a trace word at address 0x03 |
| reg_wr_i | input | 1 | Write strobe for the control register |
| reg_wdata_i | input | 2 | Control bits: bit 0 clear, bit 1 stop |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, valid in the same cycle |

## Verification
The bench runs each profile counter up to its ceiling and checks that it then stays there and keeps its overflow bit set. A design that wrapped instead would report a small count after a long residency. Six back-to-back events go into a four-entry FIFO. A design that overwrote the oldest record, or stalled, would show the wrong payloads or the wrong drop count. One event is given in the same cycle as a clear, which catches a design that records data after the clear has already wiped the FIFO. Timestamps are compared with a cycle count read at the moment of the event, so a register added or removed on the capture path shows up as an off-by-one.

// File: rtl/prof_pkg.sv
package prof_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned CTRL_W = 2;
  localparam int unsigned EVT_W  = 64;
  localparam int unsigned ENTRY_W = REG_W + EVT_W;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] ADDR_CYC   = 6'h01;
  localparam logic [ADDR_W-1:0] ADDR_DROP  = 6'h02;
  localparam logic [ADDR_W-1:0] ADDR_TRACE = 6'h03;
  localparam logic [1:0]        PROF_PAGE  = 2'b01;

  localparam int unsigned CTRL_CLEAR_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT  = 1;

  typedef enum logic [1:0] {
    W_STAMP = 2'd0,
    W_LO    = 2'd1,
    W_HI    = 2'd2
  } word_sel_e;
endpackage

// File: rtl/prof_counter.sv
module prof_counter #(
  parameter int unsigned W        = 32,
  parameter bit          SATURATE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         ovf_q;
  logic         at_max;

  assign at_max = &cnt_q;

  generate
    if (SATURATE) begin : g_sat
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
          ovf_q <= 1'b0;
        end else if (clear_i) begin
          cnt_q <= '0;
          ovf_q <= 1'b0;
        end else if (inc_i) begin
          if (at_max) ovf_q <= 1'b1;
          else        cnt_q <= cnt_q + 1'b1;
        end
      end
    end else begin : g_wrap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
          ovf_q <= 1'b0;
        end else if (clear_i) begin
          cnt_q <= '0;
          ovf_q <= 1'b0;
        end else if (inc_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (at_max) ovf_q <= 1'b1;
        end
      end
    end
  endgenerate

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/prof_cnt_bank.sv
module prof_cnt_bank #(
  parameter int unsigned N_CNT = 16,
  parameter int unsigned CNT_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   run_i,
  input  logic [N_CNT-1:0]       hit_i,
  output logic [N_CNT*CNT_W-1:0] cnt_flat_o,
  output logic [N_CNT-1:0]       ovf_o
);
  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    prof_counter #(.W(CNT_W), .SATURATE(1'b1)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(clear_i),
      .inc_i  (run_i & hit_i[i]),
      .cnt_o  (cnt_flat_o[i*CNT_W +: CNT_W]),
      .ovf_o  (ovf_o[i])
    );
  end
endmodule

// File: rtl/prof_trace_fifo.sv
module prof_trace_fifo #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned ENTRY_W = 96,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = PW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               push_i,
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic               pop_i,
  output logic [ENTRY_W-1:0] head_o,
  output logic [CW-1:0]      count_o,
  output logic               full_o,
  output logic               empty_o,
  output logic               drop_o
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o & ~clear_i;
  assign do_pop  = pop_i & ~empty_o & ~clear_i;
  assign drop_o  = push_i & full_o & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q] <= entry_i;
  end

  assign head_o  = mem[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/prof_host_if.sv
module prof_host_if
  import prof_pkg::*;
#(
  parameter int unsigned N_CNT = 16,
  parameter int unsigned CNT_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic                   reg_rd_i,
  input  logic                   reg_wr_i,
  input  logic [CTRL_W-1:0]      reg_wdata_i,
  output logic [REG_W-1:0]       reg_rdata_o,
  input  logic [REG_W-1:0]       status_i,
  input  logic [CNT_W-1:0]       cyc_i,
  input  logic [REG_W-1:0]       drop_i,
  input  logic [N_CNT*CNT_W-1:0] prof_flat_i,
  input  logic [ENTRY_W-1:0]     head_i,
  input  logic                   empty_i,
  output logic                   clear_o,
  output logic                   stop_o,
  output logic                   pop_o
);
  word_sel_e   sel_q;
  logic        stop_q;
  logic        trace_rd;
  logic [3:0]  prof_idx;

  assign clear_o  = reg_wr_i & (reg_addr_i == ADDR_CTRL) & reg_wdata_i[CTRL_CLEAR_BIT];
  assign trace_rd = reg_rd_i & (reg_addr_i == ADDR_TRACE) & ~empty_i;
  assign pop_o    = trace_rd & (sel_q == W_HI);
  assign prof_idx = reg_addr_i[3:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      sel_q  <= W_STAMP;
    end else begin
      if (reg_wr_i && reg_addr_i == ADDR_CTRL) stop_q <= reg_wdata_i[CTRL_STOP_BIT];
      if (clear_o) begin
        sel_q <= W_STAMP;
      end else if (trace_rd) begin
        case (sel_q)
          W_STAMP: sel_q <= W_LO;
          W_LO:    sel_q <= W_HI;
          default: sel_q <= W_STAMP;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = status_i;
      ADDR_CYC:  reg_rdata_o = REG_W'(cyc_i);
      ADDR_DROP: reg_rdata_o = drop_i;
      ADDR_TRACE: begin
        if (!empty_i) begin
          case (sel_q)
            W_STAMP: reg_rdata_o = head_i[REG_W-1:0];
            W_LO:    reg_rdata_o = head_i[2*REG_W-1:REG_W];
            default: reg_rdata_o = head_i[3*REG_W-1:2*REG_W];
          endcase
        end
      end
      default: begin
        if (reg_addr_i[5:4] == PROF_PAGE && int'(prof_idx) < N_CNT)
          reg_rdata_o = REG_W'(prof_flat_i[int'(prof_idx)*CNT_W +: CNT_W]);
      end
    endcase
  end

  assign stop_o = stop_q;
endmodule

// File: rtl/prof_trace_unit.sv
module prof_trace_unit
  import prof_pkg::*;
#(
  parameter int unsigned N_CNT       = 16,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned TRACE_DEPTH = 16,
  localparam int unsigned FCW = $clog2(TRACE_DEPTH) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_CNT-1:0]     prof_hit_i,
  input  logic                 evt_valid_i,
  input  logic [EVT_W-1:0]     evt_data_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_rd_i,
  input  logic                 reg_wr_i,
  input  logic [CTRL_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o
);
  logic                   clear, stopped, run, pop;
  logic [CNT_W-1:0]       cyc_cnt;
  logic                   cyc_ovf;
  logic [N_CNT*CNT_W-1:0] prof_flat;
  logic [N_CNT-1:0]       prof_ovf;
  logic [ENTRY_W-1:0]     entry, head;
  logic [FCW-1:0]         fifo_cnt;
  logic                   full, empty, drop;
  logic [REG_W-1:0]       drop_cnt;
  logic                   drop_ovf;
  logic [REG_W-1:0]       status;

  assign run   = ~stopped;
  assign entry = {evt_data_i, REG_W'(cyc_cnt)};

  prof_counter #(.W(CNT_W), .SATURATE(1'b0)) u_cyc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear),
    .inc_i(run), .cnt_o(cyc_cnt), .ovf_o(cyc_ovf)
  );

  prof_cnt_bank #(.N_CNT(N_CNT), .CNT_W(CNT_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .run_i(run),
    .hit_i(prof_hit_i), .cnt_flat_o(prof_flat), .ovf_o(prof_ovf)
  );

  prof_trace_fifo #(.DEPTH(TRACE_DEPTH), .ENTRY_W(ENTRY_W)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear),
    .push_i(evt_valid_i & run), .entry_i(entry), .pop_i(pop),
    .head_o(head), .count_o(fifo_cnt), .full_o(full), .empty_o(empty),
    .drop_o(drop)
  );

  prof_counter #(.W(REG_W), .SATURATE(1'b1)) u_drop (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear),
    .inc_i(drop), .cnt_o(drop_cnt), .ovf_o(drop_ovf)
  );

  always_comb begin
    status        = '0;
    status[0]     = empty;
    status[1]     = stopped;
    status[2]     = cyc_ovf;
    status[3]     = full;
    status[4]     = drop_ovf;
    status[15:8]  = 8'(fifo_cnt);
    status[31:16] = 16'(prof_ovf);
  end

  prof_host_if #(.N_CNT(N_CNT), .CNT_W(CNT_W)) u_host (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_addr_i(reg_addr_i), .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .status_i(status), .cyc_i(cyc_cnt), .drop_i(drop_cnt),
    .prof_flat_i(prof_flat), .head_i(head), .empty_i(empty),
    .clear_o(clear), .stop_o(stopped), .pop_o(pop)
  );
endmodule

// File: rtl/prof_trace_unit_chk.sv
module prof_trace_unit_chk #(
  parameter int unsigned N_CNT = 16,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned FCW   = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   clear_i,
  input logic                   stop_i,
  input logic                   pop_i,
  input logic                   full_i,
  input logic [CNT_W-1:0]       cyc_i,
  input logic [FCW-1:0]         fifo_cnt_i,
  input logic [31:0]            drop_cnt_i,
  input logic [N_CNT-1:0]       ovf_i,
  input logic [N_CNT*CNT_W-1:0] prof_flat_i
);
  AST_STOP_HOLDS_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !clear_i) |=> (cyc_i == $past(cyc_i))) else $error("stop"); // R7

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((ovf_i & $past(ovf_i)) == $past(ovf_i))) else $error("ovf"); // R3

  for (genvar i = 0; i < N_CNT; i++) begin : g_sat
    AST_SAT_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_i[i] && !clear_i) |=> (&prof_flat_i[i*CNT_W +: CNT_W])) else $error("sat"); // R3
  end

  AST_OCC_LE_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= FCW'(DEPTH)) else $error("occ"); // R6

  AST_DROP_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !full_i) |=> (drop_cnt_i == $past(drop_cnt_i))) else $error("drop"); // R6

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (fifo_cnt_i == '0 && drop_cnt_i == '0 && ovf_i == '0)) else $error("clr"); // R8

  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (fifo_cnt_i != '0)) else $error("pop"); // R5
endmodule

bind prof_trace_unit prof_trace_unit_chk #(
  .N_CNT(N_CNT), .CNT_W(CNT_W), .DEPTH(TRACE_DEPTH), .FCW(FCW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .stop_i(stopped),
  .pop_i(pop), .full_i(full), .cyc_i(cyc_cnt), .fifo_cnt_i(fifo_cnt),
  .drop_cnt_i(drop_cnt), .ovf_i(prof_ovf), .prof_flat_i(prof_flat)
);

// File: tb/prof_trace_unit_tb.sv
module prof_trace_unit_tb;
  localparam int N_CNT = 16;
  localparam int CNT_W = 8;
  localparam int DEPTH = 4;
  localparam logic [31:0] MSK = 32'hFF;

  // profile table: mask, hold cycles, expected cnt0, cnt1, cnt15 (cumulative)
  localparam int NROW = 4;
  localparam logic [15:0] T_MASK [NROW] = '{16'h0001, 16'h8003, 16'h0002, 16'h8000};
  localparam int          T_HOLD [NROW] = '{5, 3, 4, 10};
  localparam int          T_E0   [NROW] = '{5, 8, 8, 8};
  localparam int          T_E1   [NROW] = '{0, 3, 7, 7};
  localparam int          T_E15  [NROW] = '{0, 3, 3, 13};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hit = '0;
  logic        evt_valid = 1'b0;
  logic [63:0] evt_data = '0;
  logic [5:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [1:0]  wdata = '0;
  logic [31:0] rdata;
  int n_tests = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  prof_trace_unit #(.N_CNT(N_CNT), .CNT_W(CNT_W), .TRACE_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prof_hit_i(hit), .evt_valid_i(evt_valid),
    .evt_data_i(evt_data), .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [5:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic pop_word(output logic [31:0] v);
    addr = 6'h03; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic host_write(input logic [1:0] d);
    addr = 6'h00; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v, a, b, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    peek(6'h00, v); chk("R10 status", v, 32'h1);
    peek(6'h02, v); chk("R10 drop", v, 0);
    peek(6'h10, v); chk("R10 prof0", v, 0);
    peek(6'h03, v); chk("R5 empty read", v, 0);

    // R1 cycle counter increments
    peek(6'h01, a);
    repeat (7) @(negedge clk);
    peek(6'h01, b); chk("R1 cycle delta", b, (a + 7) & MSK);

    // R2 profile table
    host_write(2'b01);
    for (int r = 0; r < NROW; r++) begin
      hit = T_MASK[r];
      repeat (T_HOLD[r]) @(negedge clk);
      hit = '0;
      peek(6'h10, v); chk("R2 prof0", v, T_E0[r]);
      peek(6'h11, v); chk("R2 prof1", v, T_E1[r]);
      peek(6'h1F, v); chk("R2 prof15", v, T_E15[r]);
    end

    // R3 saturation
    hit = 16'h0008;
    repeat (300) @(negedge clk);
    peek(6'h13, v); chk("R3 sat value", v, 32'hFF);
    peek(6'h00, v); chk("R3 ovf bit3", {31'b0, v[19]}, 1);
    chk("R3 ovf bit0 clear", {31'b0, v[16]}, 0);
    chk("R1 cycle ovf", {31'b0, v[2]}, 1);
    repeat (5) @(negedge clk);
    hit = '0;
    peek(6'h13, v); chk("R3 sat hold", v, 32'hFF);

    // R8 clear
    host_write(2'b01);
    peek(6'h13, v); chk("R8 prof3", v, 0);
    peek(6'h00, v); chk("R8 ovf map", v[31:16], 0);
    chk("R8 cyc ovf", {31'b0, v[2]}, 0);

    // R4 single event
    peek(6'h01, c0);
    evt_valid = 1'b1; evt_data = 64'hA5A5_0001_1234_5678;
    @(negedge clk);
    evt_valid = 1'b0;
    peek(6'h00, v); chk("R4 occupancy", v[15:8], 1);
    pop_word(v); chk("R4 stamp", v, c0);
    pop_word(v); chk("R4 data lo", v, 32'h1234_5678);
    peek(6'h00, v); chk("R5 occ mid-record", v[15:8], 1);
    pop_word(v); chk("R4 data hi", v, 32'hA5A5_0001);
    peek(6'h00, v); chk("R5 empty after pop", {v[15:8], 7'b0, v[0]}, {8'd0, 8'd1});

    // R6 overflow of trace FIFO
    peek(6'h01, c0);
    evt_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      evt_data = 64'h100 + 64'(i);
      @(negedge clk);
    end
    evt_valid = 1'b0;
    peek(6'h00, v); chk("R6 occ full", v[15:8], DEPTH);
    chk("R6 full flag", {31'b0, v[3]}, 1);
    peek(6'h02, v); chk("R6 drop count", v, 2);
    for (int e = 0; e < DEPTH; e++) begin
      pop_word(a); chk("R4 stamp order", a, (c0 + e) & MSK);
      pop_word(b); chk("R6 kept payload", b, 32'h100 + e);
      pop_word(v); chk("R6 kept hi", v, 0);
    end
    pop_word(v); chk("R5 empty pop", v, 0);
    peek(6'h00, v); chk("R5 occ zero", v[15:8], 0);

    // R7 stop
    peek(6'h10, b);
    host_write(2'b10);
    peek(6'h01, a);
    hit = 16'h0001;
    evt_valid = 1'b1; evt_data = 64'h77;
    repeat (5) @(negedge clk);
    hit = '0; evt_valid = 1'b0;
    peek(6'h01, v); chk("R7 cyc frozen", v, a);
    peek(6'h10, v); chk("R7 prof frozen", v, b);
    peek(6'h00, v); chk("R7 stopped bit", {31'b0, v[1]}, 1);
    chk("R7 no trace", v[15:8], 0);
    host_write(2'b00);
    peek(6'h01, a);
    repeat (3) @(negedge clk);
    peek(6'h01, v); chk("R7 resume", v, (a + 3) & MSK);

    // R9 clear beats event
    evt_valid = 1'b1; evt_data = 64'h55;
    @(negedge clk);
    evt_data = 64'h66;
    addr = 6'h00; wdata = 2'b01; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; evt_valid = 1'b0;
    peek(6'h00, v); chk("R9 clear wins", v[15:8], 0);
    pop_word(v); chk("R9 nothing stored", v, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule